// File: doc/BRIEF.md
# Clock, Power and Reset Controller

This block sits beside the core of a small 8-bit microcontroller and owns three jobs. It halves the oscillator clock into an internal clock and tracks where the core is in each machine cycle: six states of two phases, twelve oscillator periods in all. It holds the power-control register and turns its idle and power-down bits into enables for the processor clock and the peripheral clock. It also cleans up the external reset pin and turns a qualified request into a synchronous core reset.

In idle, the processor clock stops while the peripheral clock and interrupt logic keep running, and any wake request from the interrupt logic returns the core to run. Power-down stops both clocks and drops the oscillator enable, and only a reset leaves it. The reset pin passes through a synchronizer and is looked at once per machine cycle, at state 5 phase 2. A reset takes hold only after two such samples in a row have seen the pin high, so short pulses are ignored. The core reset is released on a machine-cycle boundary. The reset values for the port latches, the stack pointer and the other special registers are driven as outputs. The serial buffer is given no reset value.

Top module: `clk_pwr_rst_ctrl`

## Requirements
- R1: `clk_int` is 0 in the first cycle after power-on reset and toggles on every rising edge of `osc_clk`.
- R2: `mc_state` runs 1 to 6. Within each state, `mc_phase` is 0 for phase 1 and then 1 for phase 2, so one machine cycle is 12 oscillator periods. After state 6 phase 2 comes state 1 phase 0.
- R3: Power-down is pcon bit 1. While it is set, `mode` is 2 and both `cpu_clk` and `per_clk` stay low. `osc_en` is low while `rst_pin` is low, and `irq_wake` leaves pcon unchanged.
- R4: Idle is pcon bit 0, with bit 1 clear. While it is set, `mode` is 1, `cpu_clk` stays low and `per_clk` follows `clk_int`.
- R5: In idle, `irq_wake` high at a clock edge clears pcon bit 0 at that edge, and the mode returns to run (`mode` 0). Shortly after, `cpu_clk` follows `clk_int` again.
- R6: With pcon bits 0 and 1 both set, power-down has priority: `mode` is 2.
- R7: The gated clocks never change while `clk_int` holds its level. Their enables switch only during the low half of `clk_int`.
- R8: `rst_pin` counts only at the state 5 phase 2 sample. A pulse that is not high at two consecutive samples never lowers `core_rst_n`.
- R9: When the pin is seen high at two consecutive samples, `core_rst_n` goes low at state 6 phase 2 of the second of those machine cycles. It stays low for as long as later samples still see the pin high.
- R10: `core_rst_n` goes high only at state 1 phase 0. After power-on reset it goes high at the first such boundary. After a pin reset it goes high at the boundary that follows the first sample seeing the pin low.
- R11: While `core_rst_n` is low, pcon is cleared except bit 4, and pcon writes are ignored. Power-on reset clears all of pcon.
- R12: `rv_port` is FFh, `rv_sp` is 07h and `rv_sfr` is 00h.
- R13: `osc_en` is high whenever `rst_pin` is high, even in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| irq_wake | input | 1 | An enabled interrupt is pending |
| pcon_we | input | 1 | Write strobe for the power-control register |
| pcon_wdata | input | 8 | Write data for the power-control register |
| clk_int | output | 1 | Oscillator clock divided by two |
| cpu_clk | output | 1 | Gated processor clock |
| per_clk | output | 1 | Gated peripheral and interrupt clock |
| osc_en | output | 1 | Oscillator run enable |
| core_rst_n | output | 1 | Synchronous core reset, active low |
| pcon_q | output | 8 | Power-control register contents |
| mode | output | 2 | 0 run, 1 idle, 2 power-down |
| mc_state | output | 3 | Machine-cycle state, 1 to 6 |
| mc_phase | output | 1 | Phase within state, 0 = phase 1, 1 = phase 2 |
| rv_port | output | 8 | Port latch reset value |
| rv_sp | output | 8 | Stack pointer reset value |
| rv_sfr | output | 8 | Reset value of the other special registers |

## Verification
If the state counter skips or wraps early, the state and phase sequence at the ports breaks within one machine cycle. The reset release then moves off the state 1 boundary. A fault in the reset counter shows as `core_rst_n` falling after a single high sample, or staying low one machine cycle too long. Either error appears within two machine cycles of the pin edge. A wrong enable update shows within one oscillator period as a gated clock that changes in the middle of a `clk_int` level, or as a clock still running two periods after idle or power-down is written.

// File: rtl/clkrst_pkg.sv
// Shared constants and types for the clock, power and reset controller.
// Assumes an 8-bit power-control register. Bit positions are fixed because
// the core decodes them.
package clkrst_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pwr_mode_e;

    localparam int PCON_W        = 8;
    localparam int PCON_IDLE_BIT = 0;
    localparam int PCON_PD_BIT   = 1;

    // bits kept across a core reset (only power-on reset clears them)
    localparam logic [PCON_W-1:0] PCON_KEEP_MASK = 8'h10;

    localparam logic [7:0] RV_PORT = 8'hFF;
    localparam logic [7:0] RV_SP   = 8'h07;
    localparam logic [7:0] RV_SFR  = 8'h00;

    // number of gated clock domains: processor and peripheral
    localparam int GCLK_N   = 2;
    localparam int GCLK_CPU = 0;
    localparam int GCLK_PER = 1;

endpackage

// File: rtl/crc_timebase.sv
// Timebase: halves the oscillator clock and counts states and phases of the
// machine cycle. It gives one-cycle strobes for the last phase of the cycle
// and for the reset-pin sample point.
// Assumes: por_n is synchronous to osc_clk and the oscillator clock runs.
module crc_timebase #(
    parameter int STATES       = 6,
    parameter int PHASES       = 2,
    parameter int SAMPLE_STATE = 5,
    parameter int SAMPLE_PHASE = 2,
    localparam int SW = $clog2(STATES + 1),
    localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic          osc_clk,
    input  logic          por_n,
    output logic          div_clk,
    output logic [SW-1:0] mc_state,
    output logic [PW-1:0] mc_phase,
    output logic          mc_last,
    output logic          sample_stb
);

    localparam logic [SW-1:0] FIRST_STATE = SW'(1);
    localparam logic [SW-1:0] LAST_STATE  = SW'(STATES);
    localparam logic [PW-1:0] LAST_PHASE  = PW'(PHASES - 1);
    localparam logic [SW-1:0] SMP_STATE   = SW'(SAMPLE_STATE);
    localparam logic [PW-1:0] SMP_PHASE   = PW'(SAMPLE_PHASE - 1);

    logic [SW-1:0] state_q;
    logic [PW-1:0] phase_q;
    logic          div_q;

    // divide-by-two toggle, independent of the input duty cycle
    always_ff @(posedge osc_clk) begin
        if (!por_n) div_q <= 1'b0;
        else        div_q <= ~div_q;
    end

    // phase counter with state counter nested above it
    always_ff @(posedge osc_clk) begin
        if (!por_n) begin
            state_q <= FIRST_STATE;
            phase_q <= '0;
        end else if (phase_q == LAST_PHASE) begin
            phase_q <= '0;
            state_q <= (state_q == LAST_STATE) ? FIRST_STATE : state_q + SW'(1);
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign div_clk    = div_q;
    assign mc_state   = state_q;
    assign mc_phase   = phase_q;
    assign mc_last    = (state_q == LAST_STATE) && (phase_q == LAST_PHASE);
    assign sample_stb = (state_q == SMP_STATE) && (phase_q == SMP_PHASE);

    assert_state_range_R2: assert property (@(posedge osc_clk) disable iff (!por_n)
        (state_q >= FIRST_STATE) && (state_q <= LAST_STATE));

    assert_cycle_wrap_R2: assert property (@(posedge osc_clk) disable iff (!por_n)
        mc_last |=> (state_q == FIRST_STATE) && (phase_q == '0));

    assert_div_toggle_R1: assert property (@(posedge osc_clk) disable iff (!por_n)
        $past(por_n) |-> (div_q != $past(div_q)));

endmodule

// File: rtl/crc_rst_qual.sv
// Reset qualifier: brings the asynchronous reset pin through a synchronizer
// chain and samples it once per machine cycle. It counts consecutive high
// samples up to a saturating limit. The core reset is asserted once the limit
// is reached and released at the next machine-cycle boundary after a low
// sample.
// Assumes sample_stb and mc_last are single-cycle strobes from the timebase.
module crc_rst_qual #(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 2,
    localparam int CW = $clog2(QUAL_SAMPLES + 1)
) (
    input  logic osc_clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic sample_stb,
    input  logic mc_last,
    output logic core_rst_n
);

    localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_SAMPLES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   rst_n_q;

    // synchronizer chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // first stage captures the raw pin
            always_ff @(posedge osc_clk) begin
                if (!por_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= rst_pin;
            end
        end else begin : g_next
            // later stages shift the value along
            always_ff @(posedge osc_clk) begin
                if (!por_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // consecutive-sample counter: a low sample restarts the count
    always_ff @(posedge osc_clk) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (sample_stb) begin
            if (!sync_q[SYNC_STAGES-1]) cnt_q <= '0;
            else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CW'(1);
        end
    end

    // core reset: asserted when qualified, released on a cycle boundary
    always_ff @(posedge osc_clk) begin
        if (!por_n)                rst_n_q <= 1'b0;
        else if (cnt_q == CNT_MAX) rst_n_q <= 1'b0;
        else if (mc_last)          rst_n_q <= 1'b1;
    end

    assign core_rst_n = rst_n_q;

    assert_release_boundary_R10: assert property (@(posedge osc_clk) disable iff (!por_n)
        ($past(por_n) && $rose(rst_n_q)) |-> $past(mc_last));

    assert_assert_after_sample_R9: assert property (@(posedge osc_clk) disable iff (!por_n)
        ($past(por_n, 2) && $fell(rst_n_q)) |-> $past(sample_stb, 2));

    assert_count_bound_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/crc_clk_gate.sv
// Glitch-free clock gates, one per domain. Each enable is re-timed on the
// falling oscillator edge and loaded only while the divided clock is low.
// A gated clock can therefore start or stop only together with the divided
// clock.
// Assumes div_clk changes only on the rising oscillator edge.
module crc_clk_gate #(
    parameter int N = 2
) (
    input  logic         osc_clk,
    input  logic         por_n,
    input  logic         div_clk,
    input  logic [N-1:0] want,
    output logic [N-1:0] gclk
);

    logic [N-1:0] en_q;

    for (genvar d = 0; d < N; d++) begin : g_dom
        // enable flop: updates only in the low half of div_clk
        always_ff @(negedge osc_clk) begin
            if (!por_n)        en_q[d] <= 1'b1;
            else if (!div_clk) en_q[d] <= want[d];
        end

        assign gclk[d] = div_clk & en_q[d];

        assert_gclk_rise_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
            ($past(por_n) && $rose(gclk[d])) |-> $rose(div_clk));

        assert_gclk_fall_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
            ($past(por_n) && $fell(gclk[d])) |-> $fell(div_clk));
    end

endmodule

// File: rtl/crc_pwr_mode.sv
// Power-mode control: holds the power-control register and decodes run, idle
// or power-down from it, with power-down taking priority. It clears the idle
// bit on a wake request and clears the register (except the kept bits) during
// core reset. It produces the per-domain clock requests and the oscillator
// enable.
// Assumes core_rst_n is already synchronous to osc_clk.
module crc_pwr_mode
    import clkrst_pkg::*;
(
    input  logic              osc_clk,
    input  logic              por_n,
    input  logic              core_rst_n,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    input  logic              irq_wake,
    input  logic              rst_pin,
    output logic [PCON_W-1:0] pcon_q,
    output pwr_mode_e         mode,
    output logic [GCLK_N-1:0] clk_want,
    output logic              osc_en
);

    logic [PCON_W-1:0] pcon_r;

    // power-control register: reset, write, then wake clears the idle bit
    always_ff @(posedge osc_clk) begin
        if (!por_n) begin
            pcon_r <= '0;
        end else if (!core_rst_n) begin
            pcon_r <= pcon_r & PCON_KEEP_MASK;
        end else if (pcon_we) begin
            pcon_r <= pcon_wdata;
        end else if (irq_wake && pcon_r[PCON_IDLE_BIT] && !pcon_r[PCON_PD_BIT]) begin
            pcon_r[PCON_IDLE_BIT] <= 1'b0;
        end
    end

    // mode decode with power-down priority
    always_comb begin
        if (pcon_r[PCON_PD_BIT])        mode = MODE_PDOWN;
        else if (pcon_r[PCON_IDLE_BIT]) mode = MODE_IDLE;
        else                            mode = MODE_RUN;
    end

    // per-domain clock requests and oscillator enable
    always_comb begin
        clk_want           = '0;
        clk_want[GCLK_CPU] = (mode == MODE_RUN);
        clk_want[GCLK_PER] = (mode != MODE_PDOWN);
        osc_en             = (mode != MODE_PDOWN) | rst_pin;
    end

    assign pcon_q = pcon_r;

    assert_idle_wake_R5: assert property (@(posedge osc_clk) disable iff (!por_n)
        (core_rst_n && !pcon_we && irq_wake && pcon_r[PCON_IDLE_BIT] && !pcon_r[PCON_PD_BIT])
        |=> !pcon_r[PCON_IDLE_BIT]);

    assert_pd_hold_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
        (core_rst_n && !pcon_we && pcon_r[PCON_PD_BIT]) |=> pcon_r[PCON_PD_BIT]);

    assert_reset_clear_R11: assert property (@(posedge osc_clk) disable iff (!por_n)
        !core_rst_n |=> ((pcon_r & ~PCON_KEEP_MASK) == '0));

endmodule

// File: rtl/clk_pwr_rst_ctrl.sv
// Clock, power and reset controller top. It ties together the timebase, the
// reset qualifier, the power-mode register and the clock gates, and drives
// the register reset values.
// Assumes: single oscillator clock, synchronous active-low power-on reset.
module clk_pwr_rst_ctrl
    import clkrst_pkg::*;
#(
    parameter int STATES       = 6,
    parameter int PHASES       = 2,
    parameter int SAMPLE_STATE = 5,
    parameter int SAMPLE_PHASE = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 2,
    localparam int SW = $clog2(STATES + 1),
    localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              osc_clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              irq_wake,
    input  logic              pcon_we,
    input  logic [PCON_W-1:0] pcon_wdata,
    output logic              clk_int,
    output logic              cpu_clk,
    output logic              per_clk,
    output logic              osc_en,
    output logic              core_rst_n,
    output logic [PCON_W-1:0] pcon_q,
    output logic [1:0]        mode,
    output logic [SW-1:0]     mc_state,
    output logic [PW-1:0]     mc_phase,
    output logic [7:0]        rv_port,
    output logic [7:0]        rv_sp,
    output logic [7:0]        rv_sfr
);

    logic              div_clk;
    logic              mc_last;
    logic              sample_stb;
    logic              rst_n_i;
    pwr_mode_e         mode_i;
    logic [GCLK_N-1:0] clk_want;
    logic [GCLK_N-1:0] gclk;

    crc_timebase #(
        .STATES(STATES), .PHASES(PHASES),
        .SAMPLE_STATE(SAMPLE_STATE), .SAMPLE_PHASE(SAMPLE_PHASE)
    ) u_tb (
        .osc_clk(osc_clk), .por_n(por_n), .div_clk(div_clk),
        .mc_state(mc_state), .mc_phase(mc_phase),
        .mc_last(mc_last), .sample_stb(sample_stb)
    );

    crc_rst_qual #(
        .SYNC_STAGES(SYNC_STAGES), .QUAL_SAMPLES(QUAL_SAMPLES)
    ) u_rq (
        .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin),
        .sample_stb(sample_stb), .mc_last(mc_last), .core_rst_n(rst_n_i)
    );

    crc_pwr_mode u_pm (
        .osc_clk(osc_clk), .por_n(por_n), .core_rst_n(rst_n_i),
        .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .irq_wake(irq_wake),
        .rst_pin(rst_pin), .pcon_q(pcon_q), .mode(mode_i),
        .clk_want(clk_want), .osc_en(osc_en)
    );

    crc_clk_gate #(.N(GCLK_N)) u_cg (
        .osc_clk(osc_clk), .por_n(por_n), .div_clk(div_clk),
        .want(clk_want), .gclk(gclk)
    );

    assign clk_int    = div_clk;
    assign cpu_clk    = gclk[GCLK_CPU];
    assign per_clk    = gclk[GCLK_PER];
    assign core_rst_n = rst_n_i;
    assign mode       = mode_i;
    assign rv_port    = RV_PORT;
    assign rv_sp      = RV_SP;
    assign rv_sfr     = RV_SFR;

    assert_pd_clocks_off_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
        (mode_i == MODE_PDOWN && $past(mode_i == MODE_PDOWN)) |-> (!cpu_clk && !per_clk));

    assert_idle_cpu_off_R4: assert property (@(posedge osc_clk) disable iff (!por_n)
        (mode_i == MODE_IDLE && $past(mode_i == MODE_IDLE)) |-> (!cpu_clk && (per_clk == div_clk)));

endmodule

// File: tb/sim_clk_pwr_rst_ctrl.sv
module sim_clk_pwr_rst_ctrl;

    localparam int PERIOD = 10;

    logic       osc_clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin = 1'b0;
    logic       irq_wake = 1'b0;
    logic       pcon_we = 1'b0;
    logic [7:0] pcon_wdata = 8'h00;
    logic       clk_int, cpu_clk, per_clk, osc_en, core_rst_n;
    logic [7:0] pcon_q, rv_port, rv_sp, rv_sfr;
    logic [1:0] mode;
    logic [2:0] mc_state;
    logic [0:0] mc_phase;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit prev_ok = 0;
    logic prev_clk, prev_cpu, prev_per;

    clk_pwr_rst_ctrl u0 (
        .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin), .irq_wake(irq_wake),
        .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .clk_int(clk_int),
        .cpu_clk(cpu_clk), .per_clk(per_clk), .osc_en(osc_en),
        .core_rst_n(core_rst_n), .pcon_q(pcon_q), .mode(mode),
        .mc_state(mc_state), .mc_phase(mc_phase),
        .rv_port(rv_port), .rv_sp(rv_sp), .rv_sfr(rv_sfr)
    );

    always #(PERIOD/2) osc_clk = ~osc_clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R7: gated clocks may not change while clk_int holds its level
    task automatic half_sample();
        if (prev_ok && clk_int == prev_clk) begin
            chk(cpu_clk == prev_cpu, "R7 cpu_clk changed mid-level", cpu_clk, prev_cpu);
            chk(per_clk == prev_per, "R7 per_clk changed mid-level", per_clk, prev_per);
        end
        prev_clk = clk_int; prev_cpu = cpu_clk; prev_per = per_clk; prev_ok = 1;
    endtask

    // advance one oscillator period; returns 2 time units after the rising edge
    task automatic step();
        #(PERIOD/2);
        half_sample();
        @(posedge osc_clk);
        #2;
        half_sample();
    endtask

    function automatic int next_tick(input int s, input int p);
        if (p == 0) return s * 2 + 1;
        return (s == 6) ? 2 : (s + 1) * 2;
    endfunction

    task automatic align(input int s, input int p);
        for (int k = 0; k < 30; k++) begin
            if (mc_state == 3'(s) && mc_phase == 1'(p)) return;
            step();
        end
        chk(0, "R2 align never reached", mc_state, s);
    endtask

    // R8/R9/R10: pin high for n whole machine cycles starting at state 1 phase 0
    task automatic pulse_cycles(input int n);
        align(1, 0);
        for (int j = 0; j <= n + 1; j++) begin
            for (int t = 0; t < 12; t++) begin
                if (t == 0) begin
                    rst_pin = (j < n);
                    chk(core_rst_n == !(n >= 2 && j >= 2 && j <= n),
                        "R10 core_rst_n at S1P1", core_rst_n, !(n >= 2 && j >= 2 && j <= n));
                end
                if (t == 11)
                    chk(core_rst_n == !(n >= 2 && j >= 1 && j <= n),
                        "R9 core_rst_n at S6P2", core_rst_n, !(n >= 2 && j >= 1 && j <= n));
                step();
            end
        end
    endtask

    task automatic write_pcon(input logic [7:0] v);
        pcon_we = 1; pcon_wdata = v;
        step();
        pcon_we = 0;
    endtask

    task automatic check_clocks(input int want_cpu, input int want_per, input string req);
        for (int k = 0; k < 12; k++) begin
            chk(cpu_clk == (want_cpu ? clk_int : 1'b0), req, cpu_clk, want_cpu ? clk_int : 0);
            chk(per_clk == (want_per ? clk_int : 1'b0), req, per_clk, want_per ? clk_int : 0);
            step();
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s, p, e;
        void'($urandom(32'd4242));
        @(posedge osc_clk);
        #2;
        repeat (3) step();
        por_n = 1;
        // reset state (R1, R2, R11, R12)
        chk(clk_int == 0, "R1 clk_int after por", clk_int, 0);
        chk(mc_state == 1 && mc_phase == 0, "R2 state after por", {mc_state, mc_phase}, 2);
        chk(core_rst_n == 0, "R10 core reset held after por", core_rst_n, 0);
        chk(pcon_q == 8'h00, "R11 pcon after por", pcon_q, 0);
        chk(rv_port == 8'hFF, "R12 rv_port", rv_port, 8'hFF);
        chk(rv_sp == 8'h07, "R12 rv_sp", rv_sp, 8'h07);
        chk(rv_sfr == 8'h00, "R12 rv_sfr", rv_sfr, 0);
        // R1/R2 sequence over two machine cycles; R10 release at first boundary
        for (int k = 0; k < 24; k++) begin
            s = mc_state; p = mc_phase;
            e = clk_int;
            if (k < 12) chk(core_rst_n == (k == 0 ? 0 : (k < 12 ? 0 : 1)),
                            "R10 held until boundary", core_rst_n, 0);
            step();
            chk(clk_int == !e, "R1 clk_int toggles", clk_int, !e);
            chk(next_tick(s, p) == mc_state * 2 + mc_phase, "R2 state/phase sequence",
                mc_state * 2 + mc_phase, next_tick(s, p));
            if (k == 11) chk(core_rst_n == 1, "R10 release after por", core_rst_n, 1);
        end

        // R9/R10 directed and random durations
        pulse_cycles(1);
        pulse_cycles(2);
        pulse_cycles(3);
        for (int r = 0; r < 6; r++) pulse_cycles(int'($urandom_range(0, 4)));

        // R8 random short pulses (shorter than a machine cycle)
        for (int r = 0; r < 10; r++) begin
            int st, ln;
            st = int'($urandom_range(0, 11));
            ln = int'($urandom_range(1, 11));
            align(1, 0);
            repeat (st) step();
            rst_pin = 1;
            repeat (ln) step();
            rst_pin = 0;
            for (int k = 0; k < 30; k++) begin
                chk(core_rst_n == 1, "R8 short pulse ignored", core_rst_n, 1);
                step();
            end
        end
        // R8 alternating high/low samples
        align(1, 0);
        for (int j = 0; j < 6; j++) begin
            rst_pin = (j % 2 == 0);
            for (int t = 0; t < 12; t++) begin
                chk(core_rst_n == 1, "R8 alternating samples ignored", core_rst_n, 1);
                step();
            end
        end
        rst_pin = 0;

        // R4/R5 idle and wake, random lengths
        for (int r = 0; r < 6; r++) begin
            write_pcon(8'h01);
            chk(pcon_q == 8'h01, "R4 idle bit written", pcon_q, 1);
            chk(mode == 2'd1, "R4 mode idle", mode, 1);
            repeat (3) step();
            check_clocks(0, 1, "R4 idle clocks");
            repeat (int'($urandom_range(0, 20))) step();
            irq_wake = 1;
            step();
            irq_wake = 0;
            chk(pcon_q[0] == 0, "R5 wake clears idle", pcon_q, 0);
            chk(mode == 2'd0, "R5 mode run", mode, 0);
            repeat (3) step();
            check_clocks(1, 1, "R5 run clocks");
        end

        // R3 power-down, irq ignored, R13 osc restart, exit by reset
        write_pcon(8'h02);
        chk(mode == 2'd2, "R3 mode pdown", mode, 2);
        repeat (3) step();
        check_clocks(0, 0, "R3 pdown clocks");
        chk(osc_en == 0, "R3 osc_en low", osc_en, 0);
        irq_wake = 1;
        step();
        irq_wake = 0;
        chk(pcon_q == 8'h02, "R3 irq ignored in pdown", pcon_q, 2);
        chk(mode == 2'd2, "R3 still pdown", mode, 2);
        rst_pin = 1;
        #1;
        chk(osc_en == 1, "R13 osc_en with pin high", osc_en, 1);
        rst_pin = 0;
        pulse_cycles(2);
        chk(pcon_q == 8'h00 && mode == 2'd0, "R3 reset leaves pdown", pcon_q, 0);

        // R6 priority and R11 kept bit
        write_pcon(8'h13);
        chk(mode == 2'd2, "R6 pdown priority", mode, 2);
        repeat (3) step();
        check_clocks(0, 0, "R6 both bits clocks");
        pulse_cycles(2);
        chk(pcon_q == 8'h10, "R11 bit 4 kept on core reset", pcon_q, 8'h10);
        chk(mode == 2'd0, "R11 mode run after reset", mode, 0);

        // R11 writes ignored during core reset
        rst_pin = 1;
        repeat (30) step();
        chk(core_rst_n == 0, "R9 long pin reset", core_rst_n, 0);
        write_pcon(8'h03);
        chk(pcon_q == 8'h10, "R11 write ignored in reset", pcon_q, 8'h10);
        rst_pin = 0;
        repeat (24) step();
        chk(core_rst_n == 1, "R10 released", core_rst_n, 1);

        // R11 power-on reset clears everything
        por_n = 0;
        step();
        por_n = 1;
        chk(pcon_q == 8'h00, "R11 por clears pcon", pcon_q, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule